// File: doc/BRIEF.md
# Write-Once Protection Register Interface

This block keeps the 16-bit protection word of a flash-style memory and decodes the short write sequences that change or display it. Bits 0 to 6 each guard one memory block against program and erase. Bit 15 guards the array against code readout. A bit at 0 means "protected". Software can only clear bits. Nothing inside the device can set a bit back to 1.

The word is held in two copies. The pending copy stands for the non-volatile cell and takes every accepted programming write. The active copy drives the protect outputs and the status reads. It is loaded from the pending copy on the first clock after each device reset. A newly programmed value therefore has no effect until the next reset. A programming write that would return any already-protected bit to 1 is refused and raises an error flag. While the device reset is asserted, the active copy is all zeros, so every block and the code are protected.

Two resets come in. `por_ni` is the power-on reset. It sets the pending copy to its erased value. `rst_ni` is the device reset. It clears the command decoder and the error flag, and it triggers the reload of the active copy.

Top module: `wo_prot_ctrl`

## Requirements
- R1: After power-on reset and device reset, the pending copy is 16'hFFFF. After the reload, `blk_wp_o[x]` equals the inverse of active bit x, `code_rp_o` equals the inverse of active bit 15, and `err_o` is 0.
- R2: A command starts with a prefix of writes. With the default settings, the prefix is data low byte 8'hAA at address 16'h1554, then 8'h55 at 16'h2AA8. If a write's address or low byte does not match the next prefix entry, the decoder returns to idle.
- R3: After the prefix, a write of low byte 8'hC0 at address 16'h1554 arms programming. The next write, at any address, replaces the pending copy with the bitwise AND of the pending copy and the full 16-bit write data.
- R4: An accepted programming write does not change the protect outputs or the status reads. The new value appears only after the next device reset.
- R5: If the programming data has a 1 in any bit that is already 0 in the pending copy, the pending copy stays unchanged and `err_o` rises.
- R6: After the prefix, a write of low byte 8'h90 at address 16'h2A54 enters status mode, and `stat_mode_o` goes to 1. In status mode, a read with `rd_addr_lsb_i`=1 returns the active copy. Any other read returns `mem_rdata_i`. After the prefix, 8'h90 at any other address returns the decoder to idle.
- R7: Outside the armed state, a write of low byte 8'hF0 at any address returns the decoder to idle, leaves status mode and clears `err_o`.
- R8: In status mode, writes other than low byte 8'hF0 are ignored, and the decoder stays in status mode.
- R9: No bit of the pending copy ever changes from 0 to 1 except through power-on reset.
- R10: While `rst_ni` is low, `blk_wp_o` is all ones and `code_rp_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous; sets the pending copy to its erased value |
| rst_ni | input | 1 | Device reset, active low, asynchronous |
| wr_en_i | input | 1 | Write cycle strobe |
| wr_addr_i | input | 16 | Write word address |
| wr_data_i | input | 16 | Write data |
| rd_addr_lsb_i | input | 1 | Least significant bit of the read word address |
| mem_rdata_i | input | 16 | Array read data, passed through in normal reads |
| rd_data_o | output | 16 | Read data |
| blk_wp_o | output | 7 | Write protect per block, 1 = protected |
| code_rp_o | output | 1 | Code readout protect, 1 = protected |
| stat_mode_o | output | 1 | Status mode is active |
| err_o | output | 1 | A programming write tried to release a protected bit |

## Verification
A decoder stuck in the wrong state shows up on the very next write. Either `stat_mode_o` flips when it should not, or a later programming write lands when it should not have. Errors in the pending copy stay hidden until a device reset. The bench therefore pulses `rst_ni` after each programming scenario and compares `blk_wp_o`, `code_rp_o` and the odd-address status read with its own model. A wrong reload shows one clock after reset release. A missing safe state shows while reset is still low.

// File: rtl/wo_prot_pkg.sv
package wo_prot_pkg;
  localparam int PROT_W   = 16;
  localparam int N_BLK    = 7;
  localparam int CODE_BIT = 15;
  localparam int CMD_W    = 8;

  typedef enum logic [1:0] {
    ST_PFX,
    ST_CMD,
    ST_ARM,
    ST_STAT
  } dec_st_e;
endpackage

// File: rtl/wo_prot_dec.sv
module wo_prot_dec
  import wo_prot_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int PFX_LEN = 2,
  parameter logic [PFX_LEN-1:0][ADDR_W-1:0] PFX_ADDR = {16'h2AA8, 16'h1554},
  parameter logic [PFX_LEN-1:0][CMD_W-1:0]  PFX_DATA = {8'h55, 8'hAA},
  parameter logic [ADDR_W-1:0] SET_ADDR  = 16'h1554,
  parameter logic [CMD_W-1:0]  SET_CMD   = 8'hC0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h2A54,
  parameter logic [CMD_W-1:0]  STAT_CMD  = 8'h90,
  parameter logic [CMD_W-1:0]  EXIT_CMD  = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PROT_W-1:0] wr_data_i,
  output logic              prog_o,
  output logic              clr_err_o,
  output logic              stat_o
);
  localparam int IDX_W = (PFX_LEN > 1) ? $clog2(PFX_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PFX_LEN - 1);

  dec_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pfx_hit, exit_hit, set_hit, stat_hit;
  logic [CMD_W-1:0] cmd;

  assign cmd      = wr_data_i[CMD_W-1:0];
  assign pfx_hit  = (wr_addr_i == PFX_ADDR[idx_q]) && (cmd == PFX_DATA[idx_q]);
  assign exit_hit = (cmd == EXIT_CMD);
  assign set_hit  = (wr_addr_i == SET_ADDR) && (cmd == SET_CMD);
  assign stat_hit = (wr_addr_i == STAT_ADDR) && (cmd == STAT_CMD);

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    prog_o    = 1'b0;
    clr_err_o = 1'b0;
    if (wr_en_i) begin
      if (st_q == ST_ARM) begin
        // data cycle takes precedence over command decode
        prog_o = 1'b1;
        st_d   = ST_PFX;
        idx_d  = '0;
      end else if (exit_hit) begin
        clr_err_o = 1'b1;
        st_d      = ST_PFX;
        idx_d     = '0;
      end else begin
        unique case (st_q)
          ST_PFX: begin
            if (!pfx_hit)              idx_d = '0;
            else if (idx_q == LAST_IDX) begin
              st_d  = ST_CMD;
              idx_d = '0;
            end else                    idx_d = idx_q + 1'b1;
          end
          ST_CMD: begin
            if (set_hit)       st_d = ST_ARM;
            else if (stat_hit) st_d = ST_STAT;
            else               st_d = ST_PFX;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_PFX;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign stat_o = (st_q == ST_STAT);

  assert_exit_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && exit_hit && st_q != ST_ARM) |=> (st_q == ST_PFX && idx_q == '0));

  assert_stat_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_STAT && wr_en_i && !exit_hit) |=> (st_q == ST_STAT));
endmodule

// File: rtl/wo_prot_store.sv
module wo_prot_store
  import wo_prot_pkg::*;
#(
  parameter logic [PROT_W-1:0] PROT_INIT = '1
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic [PROT_W-1:0] prog_data_i,
  input  logic              clr_err_i,
  output logic [PROT_W-1:0] act_o,
  output logic              err_o
);
  logic [PROT_W-1:0] nv_q, act_q;
  logic              load_q, err_q, release_hit;

  // a 1 in the data over a stored 0 would release protection
  assign release_hit = |(~nv_q & prog_data_i);

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                    nv_q <= PROT_INIT;
    else if (prog_i && !release_hit) nv_q <= nv_q & prog_data_i;
  end

  // active copy is fully protective during reset, reloads on first clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      load_q <= 1'b1;
    end else if (load_q) begin
      act_q  <= nv_q;
      load_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    err_q <= 1'b0;
    else if (prog_i && release_hit) err_q <= 1'b1;
    else if (clr_err_i)             err_q <= 1'b0;
  end

  assign act_o = act_q;
  assign err_o = err_q;

  assert_one_way_R9: assert property (@(posedge clk_i) disable iff (!por_ni)
    1'b1 |=> ((nv_q & ~$past(nv_q)) == '0));

  assert_err_keeps_R5: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (prog_i && release_hit) |=> ($stable(nv_q) && err_q));

  assert_act_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_q |=> $stable(act_q));
endmodule

// File: rtl/wo_prot_ctrl.sv
module wo_prot_ctrl
  import wo_prot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [PROT_W-1:0] PROT_INIT = '1
) (
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PROT_W-1:0] wr_data_i,
  input  logic              rd_addr_lsb_i,
  input  logic [PROT_W-1:0] mem_rdata_i,
  output logic [PROT_W-1:0] rd_data_o,
  output logic [N_BLK-1:0]  blk_wp_o,
  output logic              code_rp_o,
  output logic              stat_mode_o,
  output logic              err_o
);
  logic              prog, clr_err, stat;
  logic [PROT_W-1:0] act;

  wo_prot_dec #(.ADDR_W(ADDR_W)) dec_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .prog_o    (prog),
    .clr_err_o (clr_err),
    .stat_o    (stat)
  );

  wo_prot_store #(.PROT_INIT(PROT_INIT)) store_i (
    .clk_i       (clk_i),
    .por_ni      (por_ni),
    .rst_ni      (rst_ni),
    .prog_i      (prog),
    .prog_data_i (wr_data_i),
    .clr_err_i   (clr_err),
    .act_o       (act),
    .err_o       (err_o)
  );

  assign blk_wp_o    = ~act[N_BLK-1:0];
  assign code_rp_o   = ~act[CODE_BIT];
  assign stat_mode_o = stat;
  assign rd_data_o   = (stat && rd_addr_lsb_i) ? act : mem_rdata_i;

  assert_prog_outside_stat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog && stat));
endmodule

// File: tb/wo_prot_ctrl_tb_top.sv
`timescale 1ns/1ps
module wo_prot_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0;
  logic        rd_lsb = 1'b0;
  logic [15:0] mem_rdata = 16'h1234;
  logic [15:0] rd_data;
  logic [6:0]  blk_wp;
  logic        code_rp, stat_mode, err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] exp_act = 16'hFFFF;

  always #2.5 clk = ~clk;

  wo_prot_ctrl dut_i (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_lsb_i(rd_lsb),
    .mem_rdata_i(mem_rdata), .rd_data_o(rd_data), .blk_wp_o(blk_wp),
    .code_rp_o(code_rp), .stat_mode_o(stat_mode), .err_o(err)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prefix();
    wr(16'h1554, 16'h00AA);
    wr(16'h2AA8, 16'h0055);
  endtask

  task automatic stat_read(string req, logic [15:0] exp);
    rd_lsb = 1'b1; #1;
    chk(req, rd_data, exp);
    rd_lsb = 1'b0;
  endtask

  task automatic check_outputs(string req);
    chk(req, {9'd0, blk_wp}, {9'd0, ~exp_act[6:0]});
    chk(req, {15'd0, code_rp}, {15'd0, ~exp_act[15]});
  endtask

  task automatic dev_reset();
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk("R10 wp in reset", {9'd0, blk_wp}, 16'h007F);
    chk("R10 code in reset", {15'd0, code_rp}, 16'h0001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk); #1;
    chk("R10 wp in por", {9'd0, blk_wp}, 16'h007F);
    @(negedge clk); por_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R1 reset outputs");
    chk("R1 err", {15'd0, err}, 16'h0000);
    chk("R1 normal read", rd_data, 16'h1234);
  endtask

  task automatic t_status_read();
    prefix();
    wr(16'h2A54, 16'h0090);
    chk("R6 stat mode", {15'd0, stat_mode}, 16'h0001);
    stat_read("R6 odd read", exp_act);
    #1 chk("R6 even read", rd_data, 16'h1234);
    wr(16'h0007, 16'h00F0);
    chk("R7 leave stat", {15'd0, stat_mode}, 16'h0000);
    stat_read("R7 normal read", 16'h1234);
  endtask

  task automatic t_set_pending();
    prefix();
    wr(16'h1554, 16'h00C0);
    wr(16'h0000, 16'hFFFA);
    chk("R3 no err", {15'd0, err}, 16'h0000);
    check_outputs("R4 still old");
    prefix(); wr(16'h2A54, 16'h0090);
    stat_read("R4 old status", exp_act);
    wr(16'h0000, 16'h00F0);
    exp_act = 16'hFFFA;
    dev_reset();
    check_outputs("R3 applied");
    prefix(); wr(16'h2A54, 16'h0090);
    stat_read("R3 new status", exp_act);
    wr(16'h0000, 16'h00F0);
  endtask

  task automatic t_release_err();
    prefix();
    wr(16'h1554, 16'h00C0);
    wr(16'h0100, 16'hFFFF);
    chk("R5 err set", {15'd0, err}, 16'h0001);
    wr(16'h0000, 16'h00F0);
    chk("R7 err clear", {15'd0, err}, 16'h0000);
    dev_reset();
    check_outputs("R9 no release");
  endtask

  task automatic t_and_code();
    prefix();
    wr(16'h1554, 16'h00C0);
    wr(16'h0003, 16'h7FF2);
    chk("R3 and no err", {15'd0, err}, 16'h0000);
    exp_act = exp_act & 16'h7FF2;
    dev_reset();
    check_outputs("R3 and code");
    chk("R3 wp value", {9'd0, blk_wp}, 16'h000D);
    prefix(); wr(16'h2A54, 16'h0090);
    stat_read("R3 code status", 16'h7FF2);
    wr(16'h0000, 16'h00F0);
  endtask

  task automatic t_bad_prefix();
    wr(16'h1554, 16'h00AA); wr(16'h2AA8, 16'h0056);
    wr(16'h1554, 16'h00C0); wr(16'h0000, 16'h0000);
    wr(16'h1554, 16'h00AA); wr(16'h2AA9, 16'h0055);
    wr(16'h1554, 16'h00C0); wr(16'h0000, 16'h0000);
    chk("R2 no err", {15'd0, err}, 16'h0000);
    dev_reset();
    check_outputs("R2 mismatch ignored");
  endtask

  task automatic t_stat_ignore();
    prefix(); wr(16'h2A54, 16'h0090);
    wr(16'h1554, 16'h00C0);
    wr(16'h0000, 16'h0000);
    chk("R8 still stat", {15'd0, stat_mode}, 16'h0001);
    stat_read("R8 status read", exp_act);
    wr(16'h0000, 16'h00F0);
    dev_reset();
    check_outputs("R8 no program");
  endtask

  task automatic t_abort_f0();
    wr(16'h1554, 16'h00AA);
    wr(16'h2AA8, 16'h00F0);
    wr(16'h2AA8, 16'h0055);
    wr(16'h1554, 16'h00C0);
    wr(16'h0000, 16'h0000);
    dev_reset();
    check_outputs("R7 abort prefix");
  endtask

  task automatic t_wrong_stat_addr();
    prefix(); wr(16'h1554, 16'h0090);
    chk("R6 wrong addr", {15'd0, stat_mode}, 16'h0000);
    stat_read("R6 wrong addr read", 16'h1234);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset_state();
    t_status_read();
    t_set_pending();
    t_release_err();
    t_and_code();
    t_bad_prefix();
    t_stat_ignore();
    t_abort_f0();
    t_wrong_stat_addr();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end
endmodule